// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block sits between a processor-side request port and a main-memory port. Each set holds two lines, and each line holds one 4-byte block: one 32-bit word. A processor read or write is taken in, its tag is compared against both ways of the indexed set, and a hit is served from the local arrays. A read miss first brings the block in from memory and only then answers the processor. A write miss in copy-back mode takes a line in the set without a fill, because a whole-word write covers the entire line. Victims are chosen per set by least-recent use, and a victim is copied to memory before it is replaced only if it holds modified data.

Two control inputs are sampled with each request. One selects copy-back or write-through, and the other sends the access straight to memory without using the arrays. Two commands empty the cache. One drops every line at once. The other first copies every modified line to memory and then drops them all. Requests, commands and their completions all use a single ready pulse on the processor side. The memory side holds a request until the memory gives a one-cycle acknowledge.

Top module: `cache2w_ctrl`

## Requirements
- R1: The set index is `cpu_addr[OFF_W+IDX_W-1:OFF_W]` (bits 5:2 at the default IDX_W=4), the tag is the bits above it, and the byte offset bits are ignored. A read that hits returns the stored word with no memory transaction, and `cpu_ready` pulses in the second cycle after acceptance.
- R2: A block never occupies both ways of its set: a lookup never finds matching valid tags in both ways.
- R3: A read miss issues one memory read of line address `cpu_addr[ADDR_W-1:OFF_W]`, installs the returned word and then returns that word. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged until `mem_ack`.
- R4: The victim is an invalid way if one exists (way 0 before way 1). Otherwise it is the way not touched by the most recent hit or install in that set.
- R5: In copy-back mode (`ctl_copyback`=1) a write hit updates only the cache and marks the line modified, with no memory transaction. A write miss installs the word as a modified line without reading memory.
- R6: When the victim is valid and modified, it is written to memory at {its tag, set} before anything else happens on the memory port. A clean victim is overwritten with no memory write.
- R7: In write-through mode (`ctl_copyback`=0) every write issues one memory write. A write hit also updates the cache and leaves the line clean. A write miss does not allocate a line.
- R8: With `ctl_bypass`=1 a read is one memory read and a write is one memory write, and the cache contents are left untouched.
- R9: `cmd_inval` marks every line invalid with no memory transaction, so modified data still in the cache is discarded.
- R10: `cmd_clean_inval` writes every valid modified line to memory and then marks every line invalid.
- R11: During and after reset, all lines are invalid and clean, all recency bits are cleared, and `cpu_ready` and `mem_req` are low.
- R12: `cpu_ready` is a single-cycle pulse per request or command. It stays low while any memory transaction of that request is in progress. If a command and an access are both pending in idle, the command is taken first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_bypass | input | 1 | 1: access goes to memory, cache not used |
| ctl_copyback | input | 1 | 1: copy-back writes, 0: write-through |
| cmd_inval | input | 1 | Drop all lines, held until ready |
| cmd_clean_inval | input | 1 | Copy modified lines out, then drop all, held until ready |
| cpu_rd | input | 1 | Read request, held until ready |
| cpu_wr | input | 1 | Write request, held until ready (wins over cpu_rd) |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid with ready |
| cpu_ready | output | 1 | Completion pulse |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | ADDR_W-OFF_W | Line address |
| mem_wdata | output | 32 | Line written to memory |
| mem_rdata | input | 32 | Line read from memory, valid with ack |
| mem_ack | input | 1 | One-cycle completion of a memory transaction |

## Verification
The hardest case to reach from the ports is a modified victim that must be copied out before a fill. That needs two tags resident in one set, a write hit on one of them, a touch of the other, and then a third tag in the same set. The directed part builds that history explicitly in one set. It checks the order, address and data of the two memory transactions. Random traffic then mixes reads, writes, mode switches and clean-and-drop commands over four tags aliasing into four sets, so collisions and modified evictions recur. Every read is compared with a bench copy of memory, and after a final clean-and-drop the backing store is compared word by word.

// File: rtl/c2w_pkg.sv
package c2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FILL,
    ST_MEMWR,
    ST_RESP,
    ST_FLUSH
  } c2w_state_e;
endpackage

// File: rtl/c2w_way.sv
module c2w_way #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 18,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_dirty,
  input  logic              clr_all
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   valid_q, valid_d;
  logic [SETS-1:0]   dirty_q, dirty_d;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [DATA_W-1:0] data_mem [SETS];

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (clr_all) begin
      valid_d = '0;
      dirty_d = '0;
    end else if (wr_en) begin
      valid_d[wr_idx] = 1'b1;
      dirty_d[wr_idx] = wr_dirty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_data  = data_mem[rd_idx];

  AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_q & ~valid_q) == '0); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> valid_q == '0 && dirty_q == '0); // R9
endmodule

// File: rtl/c2w_lru.sv
module c2w_lru #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_lru,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_mru,
  input  logic             clr_all
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] lru_q, lru_d;

  always_comb begin
    lru_d = lru_q;
    if (clr_all) begin
      lru_d = '0;
    end else if (upd_en) begin
      lru_d[upd_idx] = ~upd_mru;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else begin
      lru_q <= lru_d;
    end
  end

  assign rd_lru = lru_q[rd_idx];

  AST_LRU_AWAY_FROM_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !clr_all) |=> lru_q[$past(upd_idx)] != $past(upd_mru)); // R4
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl #(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctl_bypass,
  input  logic                     ctl_copyback,
  input  logic                     cmd_inval,
  input  logic                     cmd_clean_inval,
  input  logic                     cpu_rd,
  input  logic                     cpu_wr,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic [31:0]              cpu_wdata,
  output logic [31:0]              cpu_rdata,
  output logic                     cpu_ready,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-OFF_W-1:0]  mem_addr,
  output logic [31:0]              mem_wdata,
  input  logic [31:0]              mem_rdata,
  input  logic                     mem_ack
);
  import c2w_pkg::*;

  localparam int DATA_W = 32;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int CNT_W  = IDX_W + 1;
  localparam int WAYS   = 2;
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  c2w_state_e        state_q, state_d;
  logic              is_wr_q, is_wr_d;
  logic              byp_q, byp_d;
  logic              wbm_q, wbm_d;
  logic              vict_q, vict_d;
  logic              flwb_q, flwb_d;
  logic [CNT_W-1:0]  fcnt_q, fcnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              cap_en, rdl_en;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_set;
  logic [IDX_W-1:0]  fl_set;
  logic              fl_way;
  logic [IDX_W-1:0]  rd_idx;

  logic [WAYS-1:0]   w_valid, w_dirty, way_we, hit_v;
  logic [TAG_W-1:0]  w_tag  [WAYS];
  logic [DATA_W-1:0] w_data [WAYS];
  logic [DATA_W-1:0] wr_data;
  logic              wr_dirty;
  logic              clr_all;
  logic              lru_bit, lru_upd, lru_mru;
  logic              hit, hit_way, victim;

  assign req_tag = addr_q[ADDR_W-1 -: TAG_W];
  assign req_set = addr_q[OFF_W +: IDX_W];
  assign fl_way  = fcnt_q[0];
  assign fl_set  = fcnt_q[CNT_W-1:1];
  assign rd_idx  = (state_q == ST_FLUSH) ? fl_set : req_set;

  for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
    c2w_way #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) way_i (
      .clk      (clk),
      .rst_n    (rst_ni),
      .rd_idx   (rd_idx),
      .rd_valid (w_valid[gw]),
      .rd_dirty (w_dirty[gw]),
      .rd_tag   (w_tag[gw]),
      .rd_data  (w_data[gw]),
      .wr_en    (way_we[gw]),
      .wr_idx   (req_set),
      .wr_tag   (req_tag),
      .wr_data  (wr_data),
      .wr_dirty (wr_dirty),
      .clr_all  (clr_all)
    );
    assign hit_v[gw] = w_valid[gw] && (w_tag[gw] == req_tag);
  end

  c2w_lru #(.IDX_W(IDX_W)) lru_i (
    .clk     (clk),
    .rst_n   (rst_ni),
    .rd_idx  (req_set),
    .rd_lru  (lru_bit),
    .upd_en  (lru_upd),
    .upd_idx (req_set),
    .upd_mru (lru_mru),
    .clr_all (clr_all)
  );

  assign hit     = |hit_v;
  assign hit_way = hit_v[1];
  assign victim  = !w_valid[0] ? 1'b0 : (!w_valid[1] ? 1'b1 : lru_bit);

  // next-state and output decode
  always_comb begin
    state_d   = state_q;
    is_wr_d   = is_wr_q;
    byp_d     = byp_q;
    wbm_d     = wbm_q;
    vict_d    = vict_q;
    flwb_d    = flwb_q;
    fcnt_d    = fcnt_q;
    rdata_d   = rdata_q;
    cap_en    = 1'b0;
    rdl_en    = 1'b0;
    way_we    = '0;
    wr_data   = wdata_q;
    wr_dirty  = 1'b0;
    clr_all   = 1'b0;
    lru_upd   = 1'b0;
    lru_mru   = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = addr_q[ADDR_W-1:OFF_W];
    mem_wdata = wdata_q;
    cpu_ready = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (cmd_clean_inval) begin
          flwb_d  = 1'b1;
          fcnt_d  = '0;
          state_d = ST_FLUSH;
        end else if (cmd_inval) begin
          clr_all = 1'b1;
          state_d = ST_RESP;
        end else if (cpu_rd || cpu_wr) begin
          cap_en  = 1'b1;
          is_wr_d = cpu_wr;
          byp_d   = ctl_bypass;
          wbm_d   = ctl_copyback;
          state_d = ST_LOOKUP;
        end
      end

      ST_LOOKUP: begin
        if (byp_q) begin
          state_d = is_wr_q ? ST_MEMWR : ST_FILL;
        end else if (hit) begin
          lru_upd = 1'b1;
          lru_mru = hit_way;
          if (is_wr_q) begin
            way_we[hit_way] = 1'b1;
            wr_dirty        = wbm_q;
            state_d         = wbm_q ? ST_RESP : ST_MEMWR;
          end else begin
            rdata_d = w_data[hit_way];
            rdl_en  = 1'b1;
            state_d = ST_RESP;
          end
        end else if (is_wr_q && !wbm_q) begin
          state_d = ST_MEMWR;
        end else begin
          vict_d = victim;
          if (w_valid[victim] && w_dirty[victim]) begin
            state_d = ST_WBACK;
          end else if (is_wr_q) begin
            way_we[victim] = 1'b1;
            wr_dirty       = 1'b1;
            lru_upd        = 1'b1;
            lru_mru        = victim;
            state_d        = ST_RESP;
          end else begin
            state_d = ST_FILL;
          end
        end
      end

      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {w_tag[vict_q], req_set};
        mem_wdata = w_data[vict_q];
        if (mem_ack) begin
          if (is_wr_q) begin
            way_we[vict_q] = 1'b1;
            wr_dirty       = 1'b1;
            lru_upd        = 1'b1;
            lru_mru        = vict_q;
            state_d        = ST_RESP;
          end else begin
            state_d = ST_FILL;
          end
        end
      end

      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          rdata_d = mem_rdata;
          rdl_en  = 1'b1;
          wr_data = mem_rdata;
          if (!byp_q) begin
            way_we[vict_q] = 1'b1;
            lru_upd        = 1'b1;
            lru_mru        = vict_q;
          end
          state_d = ST_RESP;
        end
      end

      ST_MEMWR: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) state_d = ST_RESP;
      end

      ST_RESP: begin
        cpu_ready = 1'b1;
        state_d   = ST_IDLE;
      end

      ST_FLUSH: begin
        if (flwb_q && w_valid[fl_way] && w_dirty[fl_way]) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = {w_tag[fl_way], fl_set};
          mem_wdata = w_data[fl_way];
        end
        if (!mem_req || mem_ack) begin
          if (fcnt_q == CNT_LAST) begin
            clr_all = 1'b1;
            state_d = ST_RESP;
          end else begin
            fcnt_d = fcnt_q + 1'b1;
          end
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
      byp_q   <= 1'b0;
      wbm_q   <= 1'b0;
      vict_q  <= 1'b0;
      flwb_q  <= 1'b0;
      fcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      is_wr_q <= is_wr_d;
      byp_q   <= byp_d;
      wbm_q   <= wbm_d;
      vict_q  <= vict_d;
      flwb_q  <= flwb_d;
      fcnt_q  <= fcnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q  <= cpu_addr;
      wdata_q <= cpu_wdata;
    end
    if (rdl_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign cpu_rdata = rdata_q;

  AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_LOOKUP) |-> $countones(hit_v) <= 1); // R2
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_we) && $stable(mem_addr)
                              && $stable(mem_wdata)); // R3
  AST_READY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_ni)
    cpu_ready |-> !mem_req); // R12
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    cpu_ready |=> !cpu_ready); // R12
  AST_WB_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_LOOKUP && !byp_q && hit && is_wr_q && wbm_q) |=> !mem_req); // R5
  AST_BYPASS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    (byp_q && state_q != ST_IDLE) |-> way_we == '0); // R8
  AST_INVAL_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_IDLE && cmd_inval && !cmd_clean_inval) |=> !mem_req); // R9
endmodule

// File: tb/cache2w_ctrl_tb_top.sv
`timescale 1ns/1ps
module cache2w_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_bypass = 1'b0;
  logic        ctl_copyback = 1'b1;
  logic        cmd_inval = 1'b0;
  logic        cmd_clean_inval = 1'b0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_req;
  logic        mem_we;
  logic [21:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #4 clk = ~clk;

  cache2w_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_bypass(ctl_bypass), .ctl_copyback(ctl_copyback),
    .cmd_inval(cmd_inval), .cmd_clean_inval(cmd_clean_inval),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // backing store, transaction counters and a short log per request
  logic [31:0] bmem [int unsigned];
  logic [31:0] arch [int unsigned];
  int n_rd, n_wr, log_n, lat;
  logic        log_we   [8];
  logic [21:0] log_line [8];
  logic [31:0] log_data [8];

  function automatic logic [31:0] mdef(input int unsigned line);
    return line * 32'h9E3779B1 + 32'h01234567;
  endfunction

  function automatic logic [31:0] mread(input int unsigned line);
    return bmem.exists(line) ? bmem[line] : mdef(line);
  endfunction

  function automatic logic [23:0] mk(input int t, input int s);
    return 24'((t << 6) | (s << 2));
  endfunction

  function automatic int unsigned ln(input logic [23:0] a);
    return 32'(a[23:2]);
  endfunction

  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (rst_n && mem_req) begin
      if (lat == 0) begin
        if (mem_we) begin
          bmem[32'(mem_addr)] = mem_wdata;
          n_wr++;
        end else begin
          mem_rdata = mread(32'(mem_addr));
          n_rd++;
        end
        if (log_n < 8) begin
          log_we[log_n]   = mem_we;
          log_line[log_n] = mem_addr;
          log_data[log_n] = mem_wdata;
          log_n++;
        end
        mem_ack = 1'b1;
        lat = $urandom_range(0, 2);
      end else begin
        lat--;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  logic [31:0] rdv;
  int          cyc;
  bit          overlap, single, tmo;

  task automatic wait_ready();
    int c;
    c = 0;
    overlap = 0;
    tmo = 0;
    do begin
      @(negedge clk);
      c++;
      if (cpu_ready && mem_req) overlap = 1;
    end while (!cpu_ready && c < 2000);
    tmo = !cpu_ready;
    cyc = c;
  endtask

  task automatic acc(input bit wr, input logic [23:0] a, input logic [31:0] d);
    n_rd = 0; n_wr = 0; log_n = 0;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = wr; cpu_rd = !wr;
    wait_ready();
    rdv = cpu_rdata;
    cpu_rd = 0; cpu_wr = 0;
    @(negedge clk);
    single = !cpu_ready;
    chk(!tmo && !overlap && single, "R12", "ready pulse", {31'd0, single}, 32'd1);
  endtask

  task automatic flush(input bit wb);
    n_rd = 0; n_wr = 0; log_n = 0;
    @(negedge clk);
    if (wb) cmd_clean_inval = 1; else cmd_inval = 1;
    wait_ready();
    cmd_clean_inval = 0; cmd_inval = 0;
    @(negedge clk);
    single = !cpu_ready;
    chk(!tmo && !overlap && single, "R12", "flush ready pulse", {31'd0, single}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d1, d2, d3, d4, d5, d6, d7, d8, d9;
    int unsigned seed;
    lat = 0; n_rd = 0; n_wr = 0; log_n = 0;
    seed = $urandom(32'h5EED);
    d1 = 32'hD1D1_0001; d2 = 32'hD2D2_0002; d3 = 32'hD3D3_0003;
    d4 = 32'hD4D4_0004; d5 = 32'hD5D5_0005; d6 = 32'hD6D6_0006;
    d7 = 32'hD7D7_0007; d8 = 32'hD8D8_0008; d9 = 32'hD9D9_0009;

    repeat (3) @(negedge clk);
    chk(cpu_ready == 0 && mem_req == 0, "R11", "outputs in reset",
        {30'd0, cpu_ready, mem_req}, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(cpu_ready == 0 && mem_req == 0, "R11", "idle after reset",
        {30'd0, cpu_ready, mem_req}, 32'd0);

    // R3 / R11: first read misses on an empty cache
    acc(0, mk(1, 3), 0);
    chk(n_rd == 1 && n_wr == 0, "R11", "cold read traffic", 32'(n_rd*16+n_wr), 32'h10);
    chk(rdv == mdef(ln(mk(1, 3))), "R3", "fill data", rdv, mdef(ln(mk(1, 3))));
    chk(log_line[0] == 22'(ln(mk(1, 3))), "R3", "fill line", 32'(log_line[0]), ln(mk(1, 3)));
    // R1: hit, offset ignored, 2-cycle answer
    acc(0, mk(1, 3) | 24'd3, 0);
    chk(n_rd == 0 && n_wr == 0, "R1", "hit traffic", 32'(n_rd + n_wr), 32'd0);
    chk(rdv == mdef(ln(mk(1, 3))), "R1", "hit data", rdv, mdef(ln(mk(1, 3))));
    chk(cyc == 2, "R1", "hit latency", 32'(cyc), 32'd2);
    // R4: second tag fills the invalid way, LRU choice afterwards
    acc(0, mk(2, 3), 0);
    chk(n_rd == 1, "R4", "second tag miss", 32'(n_rd), 32'd1);
    acc(0, mk(1, 3), 0);
    chk(n_rd == 0, "R4", "first tag kept", 32'(n_rd), 32'd0);
    acc(0, mk(3, 3), 0);
    chk(n_rd == 1 && n_wr == 0, "R6", "clean victim no write", 32'(n_wr), 32'd0);
    acc(0, mk(1, 3), 0);
    chk(n_rd == 0, "R4", "recent line survived", 32'(n_rd), 32'd0);
    acc(0, mk(2, 3), 0);
    chk(n_rd == 1, "R4", "evicted line misses", 32'(n_rd), 32'd1);
    // R5: copy-back write hit
    acc(1, mk(1, 3), d1);
    chk(n_rd == 0 && n_wr == 0, "R5", "write hit quiet", 32'(n_rd + n_wr), 32'd0);
    acc(0, mk(1, 3), 0);
    chk(rdv == d1 && n_rd == 0, "R5", "write hit data", rdv, d1);
    // R6: modified victim copied out first
    acc(0, mk(4, 3), 0);
    chk(n_wr == 0 && n_rd == 1, "R6", "clean way evicted", 32'(n_wr), 32'd0);
    acc(0, mk(5, 3), 0);
    chk(n_wr == 1 && n_rd == 1, "R6", "dirty evict traffic", 32'(n_rd*16+n_wr), 32'h11);
    chk(log_we[0] == 1 && log_line[0] == 22'(ln(mk(1, 3))), "R6", "writeback first",
        32'(log_line[0]), ln(mk(1, 3)));
    chk(log_data[0] == d1 && log_we[1] == 0, "R6", "writeback data", log_data[0], d1);
    // R5: copy-back write miss allocates without fill
    acc(1, mk(6, 7), d2);
    chk(n_rd == 0 && n_wr == 0, "R5", "write miss no traffic", 32'(n_rd + n_wr), 32'd0);
    acc(0, mk(6, 7), 0);
    chk(rdv == d2 && n_rd == 0, "R5", "allocated data", rdv, d2);
    // R7: write-through
    ctl_copyback = 0;
    acc(1, mk(6, 7), d3);
    chk(n_wr == 1 && log_data[0] == d3, "R7", "wt hit writes memory", log_data[0], d3);
    acc(0, mk(6, 7), 0);
    chk(rdv == d3 && n_rd == 0, "R7", "wt hit updates cache", rdv, d3);
    acc(1, mk(7, 9), d4);
    chk(n_wr == 1 && n_rd == 0, "R7", "wt miss writes", 32'(n_wr), 32'd1);
    acc(0, mk(7, 9), 0);
    chk(n_rd == 1 && rdv == d4, "R7", "wt miss not allocated", 32'(n_rd), 32'd1);
    // R8: bypass
    ctl_copyback = 1; ctl_bypass = 1;
    acc(0, mk(6, 7), 0);
    chk(n_rd == 1 && rdv == d3, "R8", "bypass read from memory", rdv, d3);
    acc(1, mk(6, 7), d5);
    chk(n_wr == 1 && mread(ln(mk(6, 7))) == d5, "R8", "bypass write", mread(ln(mk(6, 7))), d5);
    ctl_bypass = 0;
    acc(0, mk(6, 7), 0);
    chk(n_rd == 0 && rdv == d3, "R8", "cache untouched", rdv, d3);
    // R9: invalidate drops modified data
    acc(1, mk(6, 7), d6);
    chk(n_wr == 0, "R5", "dirty again", 32'(n_wr), 32'd0);
    flush(0);
    chk(n_rd == 0 && n_wr == 0, "R9", "invalidate quiet", 32'(n_rd + n_wr), 32'd0);
    acc(0, mk(6, 7), 0);
    chk(n_rd == 1 && rdv == d5, "R9", "modified data lost", rdv, d5);
    // R10: clean and invalidate; command wins over a pending read (R12)
    acc(1, mk(8, 1), d7);
    acc(1, mk(9, 1), d8);
    acc(1, mk(8, 2), d9);
    n_rd = 0; n_wr = 0; log_n = 0;
    @(negedge clk);
    cmd_clean_inval = 1; cpu_rd = 1; cpu_addr = mk(8, 1);
    wait_ready();
    cmd_clean_inval = 0; cpu_rd = 0;
    @(negedge clk);
    chk(!tmo && n_wr == 3 && n_rd == 0, "R12", "command taken before read",
        32'(n_rd*16+n_wr), 32'h03);
    chk(mread(ln(mk(8, 1))) == d7 && mread(ln(mk(9, 1))) == d8 && mread(ln(mk(8, 2))) == d9,
        "R10", "lines copied out", mread(ln(mk(9, 1))), d8);
    acc(0, mk(8, 1), 0);
    chk(n_rd == 1 && rdv == d7, "R10", "lines invalid after", 32'(n_rd), 32'd1);

    // random phase: four tags aliasing into four sets
    for (int i = 0; i < 400; i++) begin
      int r;
      logic [23:0] a;
      logic [31:0] d;
      r = $urandom_range(0, 99);
      a = mk(20 + $urandom_range(0, 3), $urandom_range(0, 3));
      if (r < 45) begin
        logic [31:0] e;
        e = arch.exists(ln(a)) ? arch[ln(a)] : mdef(ln(a));
        acc(0, a, 0);
        chk(rdv == e, "R3", "random read", rdv, e);
      end else if (r < 90) begin
        d = $urandom;
        acc(1, a, d);
        arch[ln(a)] = d;
      end else if (r < 96) begin
        ctl_copyback = ~ctl_copyback;
      end else begin
        flush(1);
      end
    end
    flush(1);
    foreach (arch[k]) begin
      chk(mread(k) == arch[k], "R10", "memory image", mread(k), arch[k]);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule